// File: doc/BRIEF.md
# Serial Receive Buffer with Overrun and Timeout Interrupts

This block sits between the shift engine of a synchronous serial port and the host. When a frame finishes shifting in, the engine pulses `frame_valid` with the received word. The block stores the word in a small first-in first-out buffer. The host takes words out one per `rd_en` strobe. The block reports how many entries are held, and whether the buffer is empty or full.

A frame that completes while every entry is occupied is an overrun. That frame is dropped, and a sticky overrun interrupt is raised. The full condition is judged only on the cycle the frame completes. A host read that frees a slot before then, or in that same cycle, therefore saves the frame. The host clears the interrupt by writing a 1 through a dedicated clear bit.

A second interrupt flags data that has been left unread. The block counts bit-rate tick pulses while the buffer holds data. If a set number of ticks pass with no read and no new frame, the timeout interrupt is raised.

Top module: `serial_rx_buffer`

## Requirements
- R1: While `rst` is high on a clock edge, the block returns to its idle state after that edge. In that state `empty`=1, `full`=0, `count`=0, and `ovr_irq`=0, `tmo_irq`=0 and `rd_data`=0.
- R2: Accepted frames are returned in arrival order. `count` follows the number of held entries, and `full` is 1 exactly when `count` equals DEPTH (default 8).
- R3: A read strobe on a non-empty buffer places the oldest entry on `rd_data` one clock edge after the strobe. `rd_data` keeps that value until the next read.
- R4: A frame that completes while `full`=1, with no read in the same cycle, is not stored. `ovr_irq` goes to 1 on that same clock edge.
- R5: Every further frame that completes while the buffer is still full is also dropped. None of them ever shows up on `rd_data`.
- R6: A frame is stored with no overrun if a slot is free when it completes. This holds when a read freed the slot in an earlier cycle. It also holds when a read comes in the same cycle on a full buffer, because the read frees the slot first.
- R7: `ovr_irq` stays at 1 until a cycle with `ovr_clr_wr`=1 and `ovr_clr_bit`=1. A write with `ovr_clr_bit`=0 has no effect. A clear in the same cycle as a new overrun leaves `ovr_irq` at 1.
- R8: After an overrun, frames are accepted again as soon as a slot is free. This needs neither clearing the flag nor draining the buffer.
- R9: While the buffer holds data, `tmo_irq` goes to 1 on the edge that samples the TMO_TICKS-th (default 32) `bit_tick` pulse. That count starts after the last read or accepted frame. A read or an accepted frame restarts the count.
- R10: `tmo_irq` returns to 0 on the edge after a read strobe. It is always 0 while `empty`=1.
- R11: A read strobe on an empty buffer gives `rd_data`=0 and changes neither `count` nor the order of later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | One-cycle pulse: a received frame has completed |
| frame_data | input | DW | Received word, valid with `frame_valid` |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DW | Word read out, registered |
| ovr_clr_wr | input | 1 | Host write strobe to the overrun clear bit |
| ovr_clr_bit | input | 1 | Value written to the clear bit; 1 clears |
| ovr_irq | output | 1 | Sticky overrun interrupt |
| tmo_irq | output | 1 | Receive timeout interrupt |
| empty | output | 1 | Buffer holds no entries |
| full | output | 1 | Buffer holds DEPTH entries |
| count | output | $clog2(DEPTH+1) | Number of held entries |

## Verification
The main storage path is driven with several patterns:
- a plain fill-and-drain, which checks ordering and the full flag;
- frames arriving on a full buffer, which separates a dropped frame from a stored one;
- a read issued before the completing frame, and a read issued in the same cycle as it, which distinguish a correct completion-time full check from a start-time one;
- a clear collision, which shows that a set outranks a clear.

For the timeout, the 31st and 32nd ticks are compared, which catches an off-by-one in the limit. Frames arriving partway through the count show whether a write restarts the counter. Ticks applied to an empty buffer confirm that the interrupt stays quiet.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // pointer operation selected in a cycle: {push, pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } rxb_op_e;
endpackage

// File: rtl/rxb_mem.sv
module rxb_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rzero,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // storage array, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (re)    rdata <= mem[raddr];
    else if (rzero) rdata <= '0;
  end
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_valid,
  input  logic          rd_en,
  output logic          wr_go,
  output logic          rd_go,
  output logic          drop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  rxb_op_e       op;
  logic [CW-1:0] cnt_nxt;

  // full is judged at completion; a same-cycle read frees a slot first
  assign rd_go = rd_en & ~empty;
  assign wr_go = frame_valid & (~full | rd_go);
  assign drop  = frame_valid & ~wr_go;
  assign op    = rxb_op_e'({wr_go, rd_go});

  always_comb begin
    case (op)
      OP_PUSH: cnt_nxt = count + 1'b1;
      OP_POP:  cnt_nxt = count - 1'b1;
      default: cnt_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_go) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= (cnt_nxt == CMAX);
    end
  end
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
  parameter int LIMIT = 32,
  parameter int TW    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rd_en,
  input  logic wr_go,
  input  logic empty,
  output logic tmo
);
  localparam logic [TW-1:0] TOP = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;
  logic          restart;

  assign restart = rd_en | wr_go | empty;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || rd_en || empty)           tmo <= 1'b0;
    else if (!wr_go && tick && cnt == TOP) tmo <= 1'b1;
  end
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int DW        = 8,
  parameter int DEPTH     = 8,
  parameter int TMO_TICKS = 32,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_valid,
  input  logic [DW-1:0] frame_data,
  input  logic          bit_tick,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          ovr_clr_wr,
  input  logic          ovr_clr_bit,
  output logic          ovr_irq,
  output logic          tmo_irq,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;

  logic          wr_go, rd_go, drop;
  logic [AW-1:0] wr_ptr, rd_ptr;

  rxb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .rd_en(rd_en),
    .wr_go(wr_go), .rd_go(rd_go), .drop(drop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .empty(empty), .full(full)
  );

  rxb_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(wr_go), .waddr(wr_ptr), .wdata(frame_data),
    .re(rd_go), .rzero(rd_en & empty), .raddr(rd_ptr), .rdata(rd_data)
  );

  rxb_timer #(.LIMIT(TMO_TICKS), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .tick(bit_tick), .rd_en(rd_en),
    .wr_go(wr_go), .empty(empty), .tmo(tmo_irq)
  );

  // sticky overrun flag: a new drop outranks a clear
  always_ff @(posedge clk) begin
    if (rst)                            ovr_irq <= 1'b0;
    else if (drop)                      ovr_irq <= 1'b1;
    else if (ovr_clr_wr && ovr_clr_bit) ovr_irq <= 1'b0;
  end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_valid,
  input logic          bit_tick,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          ovr_clr_wr,
  input logic          ovr_clr_bit,
  input logic          ovr_irq,
  input logic          tmo_irq,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] count
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (empty && !full && count == '0 && !ovr_irq && !tmo_irq));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r2_full_matches: assert property (@(posedge clk) disable iff (rst)
    full == (count == CW'(DEPTH)));

  a_r4_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && full && !rd_en) |=> (ovr_irq && full));

  a_r6_same_cycle_read: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && full && rd_en) |=> full);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_irq && !(ovr_clr_wr && ovr_clr_bit)) |=> ovr_irq);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr_wr && ovr_clr_bit && !(frame_valid && full && !rd_en)) |=> !ovr_irq);

  a_r9_tick_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_irq) |-> $past(bit_tick));

  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    empty |-> !tmo_irq);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !tmo_irq);

  a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !frame_valid) |=> (rd_data == '0 && empty));
endmodule

bind serial_rx_buffer rxb_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .bit_tick(bit_tick),
  .rd_en(rd_en), .rd_data(rd_data), .ovr_clr_wr(ovr_clr_wr),
  .ovr_clr_bit(ovr_clr_bit), .ovr_irq(ovr_irq), .tmo_irq(tmo_irq),
  .empty(empty), .full(full), .count(count)
);

// File: tb/tb_serial_rx_buffer.sv
module tb_serial_rx_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_valid = 1'b0;
  logic [DW-1:0] frame_data = '0;
  logic bit_tick = 1'b0;
  logic rd_en = 1'b0;
  logic ovr_clr_wr = 1'b0;
  logic ovr_clr_bit = 1'b0;
  logic [DW-1:0] rd_data;
  logic ovr_irq, tmo_irq, empty, full;
  logic [CW-1:0] count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_buffer #(.DW(DW), .DEPTH(DEPTH), .TMO_TICKS(32)) dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .bit_tick(bit_tick), .rd_en(rd_en), .rd_data(rd_data),
    .ovr_clr_wr(ovr_clr_wr), .ovr_clr_bit(ovr_clr_bit),
    .ovr_irq(ovr_irq), .tmo_irq(tmo_irq), .empty(empty), .full(full),
    .count(count)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all drivers start just after a falling edge
  task automatic push(int d);
    frame_valid = 1'b1; frame_data = DW'(d);
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic pop(output int d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic clr(bit b);
    ovr_clr_wr = 1'b1; ovr_clr_bit = b;
    @(negedge clk);
    ovr_clr_wr = 1'b0; ovr_clr_bit = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; @(negedge clk);
      bit_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic fill(int base);
    for (int i = 0; i < DEPTH; i++) push(base + i);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 count", count, 0);
    chk("R1 ovr_irq", ovr_irq, 0);
    chk("R1 tmo_irq", tmo_irq, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    int d;
    fill(8'hA0);
    chk("R2 count at full", count, DEPTH);
    chk("R2 full flag", full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      chk("R3 data order", d, 8'hA0 + i);
      @(negedge clk);
      chk("R3 data holds", rd_data, 8'hA0 + i);
    end
    chk("R2 empty after drain", empty, 1);
  endtask

  task automatic t_overrun();
    int d;
    fill(8'h10);
    chk("R4 no irq before", ovr_irq, 0);
    push(8'h55);
    chk("R4 irq on completion", ovr_irq, 1);
    chk("R4 count unchanged", count, DEPTH);
    push(8'h66);
    chk("R5 second drop count", count, DEPTH);
    pop(d);
    chk("R8 first entry", d, 8'h10);
    push(8'h77);
    chk("R8 accepted after overrun", count, DEPTH);
    chk("R7 still sticky", ovr_irq, 1);
    clr(1'b0);
    chk("R7 zero write ignored", ovr_irq, 1);
    clr(1'b1);
    chk("R7 clear", ovr_irq, 0);
    for (int i = 1; i < DEPTH; i++) begin
      pop(d);
      chk("R5 survivors", d, 8'h10 + i);
    end
    pop(d);
    chk("R5 dropped frames absent", d, 8'h77);
    chk("R5 empty", empty, 1);
  endtask

  task automatic t_rescue();
    int d;
    fill(8'h20);
    pop(d);               // read while the ninth frame is shifting in
    push(8'h88);
    chk("R6 early read rescues", count, DEPTH);
    chk("R6 no overrun", ovr_irq, 0);
    // same-cycle read and frame on a full buffer
    rd_en = 1'b1; frame_valid = 1'b1; frame_data = 8'h99;
    @(negedge clk);
    rd_en = 1'b0; frame_valid = 1'b0;
    chk("R6 same-cycle data", rd_data, 8'h21);
    chk("R6 same-cycle count", count, DEPTH);
    chk("R6 same-cycle no overrun", ovr_irq, 0);
    for (int i = 2; i < DEPTH; i++) begin
      pop(d);
      chk("R6 drain", d, 8'h20 + i);
    end
    pop(d); chk("R6 rescued word", d, 8'h88);
    pop(d); chk("R6 same-cycle word", d, 8'h99);
  endtask

  task automatic t_clear_collide();
    int d;
    fill(8'h30);
    frame_valid = 1'b1; frame_data = 8'hEE;
    ovr_clr_wr = 1'b1; ovr_clr_bit = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0; ovr_clr_wr = 1'b0; ovr_clr_bit = 1'b0;
    chk("R7 set beats clear", ovr_irq, 1);
    clr(1'b1);
    chk("R7 later clear", ovr_irq, 0);
    for (int i = 0; i < DEPTH; i++) pop(d);
    chk("R7 drained", empty, 1);
  endtask

  task automatic t_empty_read();
    int d;
    pop(d);
    chk("R11 zero data", d, 0);
    chk("R11 count", count, 0);
    chk("R11 still empty", empty, 1);
    push(8'h3C);
    push(8'h3D);
    pop(d);
    chk("R11 order kept", d, 8'h3C);
    pop(d);
    chk("R11 order kept 2", d, 8'h3D);
  endtask

  task automatic t_timeout();
    int d;
    push(8'h41);
    ticks(31);
    chk("R9 quiet at 31", tmo_irq, 0);
    ticks(1);
    chk("R9 raised at 32", tmo_irq, 1);
    pop(d);
    chk("R10 read clears", tmo_irq, 0);
    push(8'h42);
    ticks(20);
    push(8'h43);
    ticks(20);
    chk("R9 write restarts", tmo_irq, 0);
    ticks(12);
    chk("R9 raised after restart", tmo_irq, 1);
    pop(d);
    chk("R10 read clears again", tmo_irq, 0);
    chk("R10 one left", count, 1);
    ticks(20);
    pop(d);
    chk("R10 last word", d, 8'h43);
    ticks(40);
    chk("R10 quiet when empty", tmo_irq, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_overrun();
    t_rescue();
    t_clear_collide();
    t_empty_read();
    t_timeout();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule